// File: doc/BRIEF.md
# Standby Mode Controller

This block sequences a processor core into and out of its two low-power standby modes. On a light-sleep request the core is halted while the oscillator and the peripheral clocks keep running, so any pending interrupt source can bring it back. On a deep-sleep request every clock is gated off and only external events can end the sleep. When the oscillator restarts, the block waits a fixed number of cycles before it releases the peripheral clocks and the core.

The core stacks its registers before it halts. The block holds off the halt until the core reports that stacking is complete. On the way out it issues a one-cycle resume strobe with an action code. The code tells the core whether to vector to an interrupt, to carry on at the instruction after the sleep request, or to take a reset. A deep-sleep request made while the stop-disable bit is set is turned straight into a "continue" resume and nothing is halted.

Top module: `stby_ctrl`

## Requirements
- R1: After reset `cpu_halt` is 0, `osc_en` and `per_clk_en` are 1 and `resume_vld` is 0.
- R2: After `wait_req` (which takes priority over a simultaneous `stop_req`), `cpu_halt` stays 0 until `stack_done` is sampled high. From the next cycle on, `cpu_halt` is 1 while `osc_en` and `per_clk_en` stay 1.
- R3: After `stop_req` with `s_mask`=0 and a sampled `stack_done`, the next cycle shows `cpu_halt`=1, `osc_en`=0 and `per_clk_en`=0.
- R4: A `stop_req` with `s_mask`=1 halts nothing and waits for no stacking. The next cycle shows `resume_vld`=1 with `resume_act`=1 (continue) and `cpu_halt`=0.
- R5: In light sleep, each of these ends the halt: the maskable pin `irq_n` (low level when `irq_edge_mode`=0, a falling edge when it is 1), `per_irq`, `xirq_n` low, and `rst_pin_n` low. The resume strobe appears in the cycle after the event is sampled. In edge mode a pin that is already low causes no wake.
- R6: In deep sleep, `per_irq` and a level-mode low on `irq_n` are ignored, and the block stays halted with clocks off.
- R7: In deep sleep, a falling edge on `irq_n` in edge mode, `xirq_n` low or `rst_pin_n` low ends the sleep.
- R8: After a deep-sleep wake, `osc_en` returns to 1 at once. `cpu_halt`=1 and `per_clk_en`=0 are held for exactly `SETTLE_CYC` cycles, then the resume cycle follows with all clocks on.
- R9: Resume codes are 0 none, 1 continue, 2 service interrupt, 3 reset. A maskable or internal wake, or `xirq_n` with `x_mask`=0, yields 2. A wake by `xirq_n` alone with `x_mask`=1 yields 1.
- R10: `rst_pin_n` low overrides every other action with code 3. This holds while stacking (resume follows at once), in either sleep, and during the settle count.
- R11: `resume_vld` lasts one cycle, after which `cpu_halt` is 0 and `resume_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| wait_req | input | 1 | One-cycle light-sleep request from the core |
| stop_req | input | 1 | One-cycle deep-sleep request from the core |
| s_mask | input | 1 | Stop-disable bit; 1 turns a deep-sleep request into a no-op |
| x_mask | input | 1 | Non-maskable pin mask bit |
| stack_done | input | 1 | Core reports that register stacking has finished |
| irq_n | input | 1 | External maskable request, active low |
| irq_edge_mode | input | 1 | 1: `irq_n` acts on falling edges, 0: on low level |
| xirq_n | input | 1 | External non-maskable pin, active low |
| per_irq | input | 1 | OR of internal peripheral interrupt requests |
| rst_pin_n | input | 1 | External reset pin, active low |
| cpu_halt | output | 1 | Holds the core halted |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| resume_vld | output | 1 | One-cycle resume strobe |
| resume_act | output | 2 | Resume action code (see R9) |

## Verification
The bench builds the block with `SETTLE_CYC`=5. At that value the whole deep-sleep exit, settle window included, fits in a few cycles, so every settle cycle can be checked one by one. The bench then sweeps both sleep modes against both stop-disable settings, every wake source and both `x_mask` values, and works out the expected action code and the expected wake-or-ignore outcome arithmetically for each combination. Separate sequences cover a reset pin during stacking and during settle, simultaneous requests, and an edge-mode pin that is already low.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STK_W  = 3'd1,
        ST_STK_S  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_STOP   = 3'd4,
        ST_SETTLE = 3'd5,
        ST_RESUME = 3'd6
    } stby_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CONT = 2'd1,
        ACT_SVC  = 2'd2,
        ACT_RST  = 2'd3
    } resume_act_e;

    typedef struct packed {
        stby_state_e state;
        resume_act_e act;
    } stby_regs_t;

    // Reset dominates, then anything to be serviced, else plain continue.
    function automatic resume_act_e pick_action(input logic rst_ev, input logic svc_ev);
        if (rst_ev)
            return ACT_RST;
        else if (svc_ev)
            return ACT_SVC;
        else
            return ACT_CONT;
    endfunction

endpackage

// File: rtl/stby_wake_src.sv
module stby_wake_src
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_n,
    input  logic        irq_edge_mode,
    input  logic        xirq_n,
    input  logic        per_irq,
    input  logic        rst_pin_n,
    input  logic        x_mask,
    output logic        irq_fall,
    output logic        rst_ev,
    output logic        wake_light,
    output logic        wake_deep,
    output resume_act_e act_light,
    output resume_act_e act_deep
);

    typedef struct packed {
        logic irq_prev;
    } src_regs_t;

    src_regs_t cur_q, nxt_d;

    logic irq_ev_light;
    logic irq_ev_deep;
    logic nmi_ev;
    logic nmi_svc;
    logic svc_light;
    logic svc_deep;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.irq_prev = irq_n;

        irq_fall     = cur_q.irq_prev & ~irq_n;
        irq_ev_light = irq_edge_mode ? irq_fall : ~irq_n;
        irq_ev_deep  = irq_edge_mode & irq_fall;
        nmi_ev       = ~xirq_n;
        nmi_svc      = nmi_ev & ~x_mask;
        rst_ev       = ~rst_pin_n;

        svc_light  = irq_ev_light | per_irq | nmi_svc;
        svc_deep   = irq_ev_deep | nmi_svc;
        wake_light = rst_ev | nmi_ev | irq_ev_light | per_irq;
        wake_deep  = rst_ev | nmi_ev | irq_ev_deep;
        act_light  = pick_action(rst_ev, svc_light);
        act_deep   = pick_action(rst_ev, svc_deep);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q.irq_prev <= 1'b1;
        else
            cur_q <= nxt_d;
    end

    // R7: a detected falling edge means the pin was high one cycle earlier
    p_fall_needs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fall |-> $past(irq_n));

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
    parameter int SETTLE_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW              = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = run && (cur_q.cnt == LAST);
        if (!run || done)
            nxt_d.cnt = '0;
        else
            nxt_d.cnt = cur_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q.cnt <= '0;
        else
            cur_q <= nxt_d;
    end

    // R8: the settle count never runs past its programmed length
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cur_q.cnt <= LAST);

    // R8: an interrupted run restarts from zero
    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cur_q.cnt == '0);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int SETTLE_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       s_mask,
    input  logic       x_mask,
    input  logic       stack_done,
    input  logic       irq_n,
    input  logic       irq_edge_mode,
    input  logic       xirq_n,
    input  logic       per_irq,
    input  logic       rst_pin_n,
    output logic       cpu_halt,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       resume_vld,
    output logic [1:0] resume_act
);

    stby_regs_t  cur_q, nxt_d;

    logic        irq_fall;
    logic        rst_ev;
    logic        wake_light;
    logic        wake_deep;
    resume_act_e act_light;
    resume_act_e act_deep;
    logic        settle_run;
    logic        settle_done;

    stby_wake_src u_src (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_n         (irq_n),
        .irq_edge_mode (irq_edge_mode),
        .xirq_n        (xirq_n),
        .per_irq       (per_irq),
        .rst_pin_n     (rst_pin_n),
        .x_mask        (x_mask),
        .irq_fall      (irq_fall),
        .rst_ev        (rst_ev),
        .wake_light    (wake_light),
        .wake_deep     (wake_deep),
        .act_light     (act_light),
        .act_deep      (act_deep)
    );

    assign settle_run = (cur_q.state == ST_SETTLE);

    stby_settle_cnt #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_RUN: begin
                nxt_d.act = ACT_NONE;
                if (wait_req) begin
                    nxt_d.state = ST_STK_W;
                end else if (stop_req) begin
                    if (s_mask) begin
                        nxt_d.state = ST_RESUME;
                        nxt_d.act   = ACT_CONT;
                    end else begin
                        nxt_d.state = ST_STK_S;
                    end
                end
            end
            ST_STK_W, ST_STK_S: begin
                if (rst_ev) begin
                    nxt_d.state = ST_RESUME;
                    nxt_d.act   = ACT_RST;
                end else if (stack_done) begin
                    nxt_d.state = (cur_q.state == ST_STK_W) ? ST_WAIT : ST_STOP;
                end
            end
            ST_WAIT: begin
                if (wake_light) begin
                    nxt_d.state = ST_RESUME;
                    nxt_d.act   = act_light;
                end
            end
            ST_STOP: begin
                if (wake_deep) begin
                    nxt_d.state = ST_SETTLE;
                    nxt_d.act   = act_deep;
                end
            end
            ST_SETTLE: begin
                if (rst_ev)
                    nxt_d.act = ACT_RST;
                if (settle_done)
                    nxt_d.state = ST_RESUME;
            end
            ST_RESUME: begin
                nxt_d.state = ST_RUN;
                nxt_d.act   = ACT_NONE;
            end
            default: begin
                nxt_d.state = ST_RUN;
                nxt_d.act   = ACT_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_RUN;
            cur_q.act   <= ACT_NONE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        cpu_halt   = (cur_q.state == ST_WAIT) || (cur_q.state == ST_STOP) ||
                     (cur_q.state == ST_SETTLE);
        osc_en     = (cur_q.state != ST_STOP);
        per_clk_en = (cur_q.state != ST_STOP) && (cur_q.state != ST_SETTLE);
        resume_vld = (cur_q.state == ST_RESUME);
        resume_act = resume_vld ? cur_q.act : ACT_NONE;
    end

    // R2: the halt only rises after stacking was reported
    p_halt_after_stack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> $past(stack_done));

    // R4: a masked stop request returns a continue strobe without halting
    p_stop_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_RUN && stop_req && !wait_req && s_mask)
        |=> (resume_vld && !cpu_halt && resume_act == ACT_CONT));

    // R6: without an external event deep sleep keeps the clocks off
    p_deep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STOP && rst_pin_n && xirq_n && !irq_fall)
        |=> (cpu_halt && !osc_en && !per_clk_en));

    // R10: reset pin during light sleep yields a reset action next cycle
    p_rst_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_WAIT && !rst_pin_n)
        |=> (resume_vld && resume_act == ACT_RST));

    // R11: the resume strobe is a single cycle and the core runs after it
    p_resume_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |=> (!resume_vld && !cpu_halt));

    // R8: the core is released only with both clocks running
    p_resume_clocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_halt) |-> (osc_en && per_clk_en && resume_vld));

endmodule

// File: tb/stby_ctrl_test.sv
`timescale 1ns/1ps
module stby_ctrl_test;

    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wait_req, stop_req, s_mask, x_mask, stack_done;
    logic       irq_n, irq_edge_mode, xirq_n, per_irq, rst_pin_n;
    logic       cpu_halt, per_clk_en, osc_en, resume_vld;
    logic [1:0] resume_act;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    stby_ctrl #(.SETTLE_CYC(N)) uut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .s_mask(s_mask), .x_mask(x_mask), .stack_done(stack_done),
        .irq_n(irq_n), .irq_edge_mode(irq_edge_mode), .xirq_n(xirq_n),
        .per_irq(per_irq), .rst_pin_n(rst_pin_n), .cpu_halt(cpu_halt),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .resume_vld(resume_vld),
        .resume_act(resume_act)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int h, input int o, input int p, input int v);
        chk({tag, " halt"}, int'(cpu_halt), h);
        chk({tag, " osc"},  int'(osc_en), o);
        chk({tag, " per"},  int'(per_clk_en), p);
        chk({tag, " vld"},  int'(resume_vld), v);
    endtask

    task automatic idle();
        wait_req = 0; stop_req = 0; stack_done = 0;
        irq_n = 1; xirq_n = 1; per_irq = 0; rst_pin_n = 1;
    endtask

    task automatic expect_resume(input string tag, input int act);
        chk_out({tag, " resume"}, 0, 1, 1, 1);
        chk({tag, " act"}, int'(resume_act), act);
        idle();
        @(negedge clk);
        chk_out({tag, " R11 after"}, 0, 1, 1, 0);
    endtask

    task automatic settle_then_resume(input string tag, input int act);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            chk_out({tag, " R8 settle"}, 1, 1, 0, 0);
        end
        @(negedge clk);
        expect_resume({tag, " R8"}, act);
    endtask

    task automatic enter(input int deep);
        if (deep != 0) stop_req = 1; else wait_req = 1;
        @(negedge clk);
        wait_req = 0; stop_req = 0;
    endtask

    task automatic stack_and_halt(input int deep);
        chk_out("R2 stacking", 0, 1, 1, 0);
        @(negedge clk);
        chk_out("R2 stacking hold", 0, 1, 1, 0);
        stack_done = 1;
        @(negedge clk);
        stack_done = 0;
        if (deep != 0) chk_out("R3 deep halted", 1, 0, 0, 0);
        else           chk_out("R2 light halted", 1, 1, 1, 0);
    endtask

    // src: 0 level irq, 1 edge irq, 2 internal, 3 non-maskable pin, 4 reset pin
    task automatic run_case(input int deep, input int s, input int src, input int x);
        int wakes, act;
        idle();
        irq_edge_mode = (src == 1);
        s_mask = s[0];
        x_mask = x[0];
        @(negedge clk);
        enter(deep);
        if (deep != 0 && s != 0) begin
            chk_out("R4 noop", 0, 1, 1, 1);
            chk("R4 act", int'(resume_act), 1);
            @(negedge clk);
            chk_out("R11 noop after", 0, 1, 1, 0);
            return;
        end
        stack_and_halt(deep);
        wakes = (deep == 0 || src == 1 || src == 3 || src == 4) ? 1 : 0;
        act   = (src == 4) ? 3 :
                ((src <= 2) || (src == 3 && x == 0)) ? 2 : 1;
        case (src)
            0, 1: irq_n = 0;
            2:    per_irq = 1;
            3:    xirq_n = 0;
            default: rst_pin_n = 0;
        endcase
        if (wakes == 0) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk_out("R6 ignored", 1, 0, 0, 0);
            end
            idle();
            rst_pin_n = 0;
            settle_then_resume("R10 deep reset", 3);
        end else if (deep != 0) begin
            settle_then_resume((src == 4) ? "R10 R7" : "R7 R9", act);
        end else begin
            @(negedge clk);
            expect_resume((src == 4) ? "R5 R10" : "R5 R9", act);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        s_mask = 0; x_mask = 0; irq_edge_mode = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_out("R1 reset", 0, 1, 1, 0);
        chk("R1 act", int'(resume_act), 0);

        for (int deep = 0; deep < 2; deep++)
            for (int s = 0; s < 2; s++)
                for (int src = 0; src < 5; src++)
                    for (int x = 0; x < 2; x++)
                        run_case(deep, s, src, x);

        // R2: simultaneous requests take the light-sleep path
        idle(); s_mask = 0;
        wait_req = 1; stop_req = 1;
        @(negedge clk);
        wait_req = 0; stop_req = 0;
        stack_and_halt(0);
        per_irq = 1;
        @(negedge clk);
        expect_resume("R2 both req R9", 2);

        // R10: reset pin while stacking gives an immediate reset resume
        idle();
        enter(1);
        chk_out("R10 stacking", 0, 1, 1, 0);
        rst_pin_n = 0;
        @(negedge clk);
        expect_resume("R10 during stack", 3);

        // R10: reset pin during settle upgrades a continue to reset
        idle(); x_mask = 1;
        enter(1);
        stack_and_halt(1);
        xirq_n = 0;
        @(negedge clk);
        xirq_n = 1;
        chk_out("R8 settle first", 1, 1, 0, 0);
        rst_pin_n = 0;
        @(negedge clk);
        rst_pin_n = 1;
        chk_out("R8 settle second", 1, 1, 0, 0);
        for (int i = 2; i < N; i++) begin
            @(negedge clk);
            chk_out("R8 settle rest", 1, 1, 0, 0);
        end
        @(negedge clk);
        expect_resume("R10 settle upgrade", 3);

        // R5: edge mode with the pin already low does not wake light sleep
        idle(); irq_edge_mode = 1; x_mask = 0;
        irq_n = 0;
        @(negedge clk);
        enter(0);
        stack_and_halt(0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_out("R5 low not edge", 1, 1, 1, 0);
        end
        irq_n = 1;
        @(negedge clk);
        chk_out("R5 released", 1, 1, 1, 0);
        irq_n = 0;
        @(negedge clk);
        expect_resume("R5 new edge", 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule